// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter Chain

This block keeps wall-clock time and calendar date as a cascade of 4-bit BCD digit registers. A prescaler divides an enable that pulses at the reference rate (nominally 32.768 kHz) down to a one-per-second count strobe, and it also provides a 64 Hz square wave for a standard-pulse pin. Each second strobe ripples through seconds, minutes and hours, then through day of month, month and two-digit year. A day-of-week digit advances alongside the day.

A host loads single digits through a write strobe with a 4-bit digit select and reads any digit back through a combinational read select. Hours run either as a 24-hour clock or as a 12-hour clock. In the 12-hour form, bit 2 of the tens-of-hours digit carries the afternoon flag. Leap years get a 29th of February. A one-cycle adjust request rounds the time to the nearest minute. Separate stop and reset controls halt counting, and the reset control also clears the sub-second prescaler. Registered one-cycle pulses mark the carries out of the seconds, minutes and hours stages.

Digit selects: 0 seconds ones, 1 seconds tens, 2 minutes ones, 3 minutes tens, 4 hours ones, 5 hours tens, 6 day ones, 7 day tens, 8 month ones, 9 month tens, 10 year ones, 11 year tens, 12 weekday. Selects 13 to 15 read as zero.

Top module: `bcd_calendar_core`

## Requirements
- R1: After rst_n is released, the digits read as time 00:00:00, date day 01 month 01 year 00, and weekday 0. All carry pulses are 0 and the 24-hour mode is active.
- R2: Each second strobe advances the seconds digits in BCD, wrapping 59 to 00. On the wrap, minutes advance and sec_carry is high for exactly the one cycle in which the new value first appears.
- R3: In 24-hour mode, minutes wrap 59 to 00 and advance the hours, and hours wrap 23 to 00. On that wrap, hour_carry and min_carry pulse and the day advances.
- R4: In 12-hour mode, hours run 12, 1, 2 … 11, and hours tens reads 1 for 10 to 12. Bit 2 of the hours-tens digit (1 = PM) toggles on the 11-to-12 step. The day advances only on the PM-to-AM step.
- R5: The mode select is sampled only while reset_req is high. Changing mode24_sel with reset_req low has no effect on hour counting.
- R6: A year whose value is divisible by 4 (00 included) is a leap year. In a leap year 28 February advances to 29 February, which advances to 1 March. In other years 28 February advances to 1 March.
- R7: Day rollover follows month length: 30 days for April, June, September and November, and 31 days for the rest. Month wraps 12 to 01 and advances the year, and year wraps 99 to 00.
- R8: adj30_req with seconds 00-29 clears the seconds and leaves the minutes unchanged. With seconds 30-59 it clears the seconds, advances the minutes with full carry, and pulses sec_carry.
- R9: While stop_req is high, no digit advances and the prescaler is frozen.
- R10: While reset_req is high, counting is held and the prescaler is cleared. The first second strobe after release arrives exactly 2^DIV_BITS reference enables later.
- R11: A digit write in the same cycle as an increment of that digit loads the written value.
- R12: The weekday advances on every day carry and wraps from 6 to 0.
- R13: std_pulse is a square wave whose period is 2^(DIV_BITS-6) reference enables, which is 64 Hz at the default 32.768 kHz. It holds while counting is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | One-cycle enable at the reference rate |
| stop_req | input | 1 | Halts prescaler and counting |
| reset_req | input | 1 | Clears prescaler, holds counting, opens mode sampling |
| mode24_sel | input | 1 | 1 = 24-hour, 0 = 12-hour (taken while reset_req high) |
| adj30_req | input | 1 | Round-to-nearest-minute request |
| wr_en | input | 1 | Digit write strobe |
| wr_addr | input | 4 | Digit select for writes |
| wr_data | input | 4 | Digit value to load |
| rd_addr | input | 4 | Digit select for reads |
| rd_data | output | 4 | Selected digit value |
| sec_carry | output | 1 | Pulse on carry out of seconds |
| min_carry | output | 1 | Pulse on carry out of minutes |
| hour_carry | output | 1 | Pulse on carry out of hours into the day |
| std_pulse | output | 1 | 64 Hz square wave from the prescaler |

## Verification
The hardest conditions to reach are those that need a full carry ripple landing on a calendar edge, such as the last second of 28 February in a leap year or 31 December of year 99. Counting into them from reset would take far too long. The bench stops the prescaler, writes the digits to one second before the edge, releases the stop, and watches for the single step. Write-versus-increment priority needs a write in the exact cycle of a second strobe. The bench gets there by clearing the prescaler with reset_req and counting the known number of reference enables to that strobe.

// File: rtl/cal_pkg.sv
// Package: shared digit selects and BCD/calendar helper functions.
// Assumes digits hold BCD values; helpers tolerate out-of-range input.
package cal_pkg;
    localparam logic [3:0] SEL_S1  = 4'd0;
    localparam logic [3:0] SEL_S10 = 4'd1;
    localparam logic [3:0] SEL_M1  = 4'd2;
    localparam logic [3:0] SEL_M10 = 4'd3;
    localparam logic [3:0] SEL_H1  = 4'd4;
    localparam logic [3:0] SEL_H10 = 4'd5;
    localparam logic [3:0] SEL_D1  = 4'd6;
    localparam logic [3:0] SEL_D10 = 4'd7;
    localparam logic [3:0] SEL_MO1 = 4'd8;
    localparam logic [3:0] SEL_MO10 = 4'd9;
    localparam logic [3:0] SEL_Y1  = 4'd10;
    localparam logic [3:0] SEL_Y10 = 4'd11;
    localparam logic [3:0] SEL_WK  = 4'd12;

    // Two BCD digits to a binary value.
    function automatic logic [7:0] bcd2bin(input logic [3:0] hi, input logic [3:0] lo);
        return 8'(hi) * 8'd10 + 8'(lo);
    endfunction

    // Last day of a month given as binary 1..12.
    function automatic logic [7:0] month_len(input logic [7:0] mon, input logic leap);
        case (mon)
            8'd2:                    return leap ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11: return 8'd30;
            default:                 return 8'd31;
        endcase
    endfunction
endpackage

// File: rtl/cal_prescaler.sv
// Prescaler: binary divider of the reference enable.
// Emits a one-cycle strobe each 2^DIV_BITS enables and a 64 Hz tap.
// Assumes DIV_BITS >= 7 so the 64 Hz tap exists.
module cal_prescaler #(
    parameter int DIV_BITS = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick,
    input  logic run,
    input  logic clear,
    output logic sec_tick,
    output logic tap64
);
    localparam int TAP_BIT = DIV_BITS - 7;

    logic [DIV_BITS-1:0] count;

    // Divider register: cleared by clear, advanced on enabled reference ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            count <= '0;
        else if (ref_tick && run)
            count <= count + 1'b1;
    end

    assign sec_tick = ref_tick && run && !clear && (&count);
    assign tap64    = count[TAP_BIT];
endmodule

// File: rtl/cal_time_chain.sv
// Time chain: seconds, minutes and hours BCD digits.
// Handles 24/12-hour counting, the PM flag in hours-tens bit 2, and
// the round-to-minute adjust. A host write overrides the selected digit.
module cal_time_chain
    import cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    input  logic       adj_req,
    input  logic       mode24,
    input  logic       wr_en,
    input  logic [3:0] wr_addr,
    input  logic [3:0] wr_data,
    output logic [3:0] s1,
    output logic [3:0] s10,
    output logic [3:0] m1,
    output logic [3:0] m10,
    output logic [3:0] h1,
    output logic [3:0] h10,
    output logic       c_sec,
    output logic       c_min,
    output logic       c_hr
);
    logic [3:0] n_s1, n_s10, n_m1, n_m10, n_h1, n_h10;
    logic       tens_n, pm_n;

    // Next-state of all time digits plus stage carries.
    always_comb begin
        n_s1 = s1; n_s10 = s10; n_m1 = m1; n_m10 = m10; n_h1 = h1; n_h10 = h10;
        c_sec = 1'b0; c_min = 1'b0; c_hr = 1'b0;
        tens_n = h10[0]; pm_n = h10[2];
        if (adj_req) begin
            n_s1 = 4'd0; n_s10 = 4'd0;
            c_sec = (s10 >= 4'd3);
        end else if (sec_tick) begin
            if (s1 >= 4'd9) begin
                n_s1 = 4'd0;
                if (s10 >= 4'd5) begin n_s10 = 4'd0; c_sec = 1'b1; end
                else n_s10 = s10 + 4'd1;
            end else n_s1 = s1 + 4'd1;
        end
        if (c_sec) begin
            if (m1 >= 4'd9) begin
                n_m1 = 4'd0;
                if (m10 >= 4'd5) begin n_m10 = 4'd0; c_min = 1'b1; end
                else n_m10 = m10 + 4'd1;
            end else n_m1 = m1 + 4'd1;
        end
        if (c_min) begin
            if (mode24) begin
                if (h10[1:0] >= 2'd2 && h1 >= 4'd3) begin
                    n_h1 = 4'd0; n_h10 = 4'd0; c_hr = 1'b1;
                end else if (h1 >= 4'd9) begin
                    n_h1 = 4'd0; n_h10 = h10 + 4'd1;
                end else n_h1 = h1 + 4'd1;
            end else begin
                if (h10[0] && h1 >= 4'd2) begin
                    n_h1 = 4'd1; tens_n = 1'b0;
                end else if (h10[0] && h1 == 4'd1) begin
                    n_h1 = 4'd2; pm_n = !h10[2]; c_hr = h10[2];
                end else if (h1 >= 4'd9) begin
                    n_h1 = 4'd0; tens_n = 1'b1;
                end else n_h1 = h1 + 4'd1;
                n_h10 = {1'b0, pm_n, 1'b0, tens_n};
            end
        end
        if (wr_en) begin
            case (wr_addr)
                SEL_S1:  n_s1  = wr_data;
                SEL_S10: n_s10 = wr_data;
                SEL_M1:  n_m1  = wr_data;
                SEL_M10: n_m10 = wr_data;
                SEL_H1:  n_h1  = wr_data;
                SEL_H10: n_h10 = wr_data;
                default: ;
            endcase
        end
    end

    // Time digit registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= '0; s10 <= '0; m1 <= '0; m10 <= '0; h1 <= '0; h10 <= '0;
        end else begin
            s1 <= n_s1; s10 <= n_s10; m1 <= n_m1; m10 <= n_m10; h1 <= n_h1; h10 <= n_h10;
        end
    end
endmodule

// File: rtl/cal_date_chain.sv
// Date chain: day, month, year and weekday digits.
// Advances on the hour-stage carry, using month length and a
// divisible-by-four leap rule. A host write overrides the selected digit.
module cal_date_chain
    import cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       inc_day,
    input  logic       wr_en,
    input  logic [3:0] wr_addr,
    input  logic [3:0] wr_data,
    output logic [3:0] d1,
    output logic [3:0] d10,
    output logic [3:0] mo1,
    output logic [3:0] mo10,
    output logic [3:0] y1,
    output logic [3:0] y10,
    output logic [3:0] wk
);
    logic [3:0] n_d1, n_d10, n_mo1, n_mo10, n_y1, n_y10, n_wk;
    logic [7:0] day_b, mon_b, yr_b;
    logic       leap, inc_mon, inc_yr;

    assign day_b = bcd2bin(d10, d1);
    assign mon_b = bcd2bin(mo10, mo1);
    assign yr_b  = bcd2bin(y10, y1);
    assign leap  = (yr_b[1:0] == 2'b00);

    // Next-state of all date digits.
    always_comb begin
        n_d1 = d1; n_d10 = d10; n_mo1 = mo1; n_mo10 = mo10;
        n_y1 = y1; n_y10 = y10; n_wk = wk;
        inc_mon = 1'b0; inc_yr = 1'b0;
        if (inc_day) begin
            n_wk = (wk >= 4'd6) ? 4'd0 : wk + 4'd1;
            if (day_b >= month_len(mon_b, leap)) begin
                n_d1 = 4'd1; n_d10 = 4'd0; inc_mon = 1'b1;
            end else if (d1 >= 4'd9) begin
                n_d1 = 4'd0; n_d10 = d10 + 4'd1;
            end else n_d1 = d1 + 4'd1;
        end
        if (inc_mon) begin
            if (mon_b >= 8'd12) begin
                n_mo1 = 4'd1; n_mo10 = 4'd0; inc_yr = 1'b1;
            end else if (mo1 >= 4'd9) begin
                n_mo1 = 4'd0; n_mo10 = mo10 + 4'd1;
            end else n_mo1 = mo1 + 4'd1;
        end
        if (inc_yr) begin
            if (yr_b >= 8'd99) begin
                n_y1 = 4'd0; n_y10 = 4'd0;
            end else if (y1 >= 4'd9) begin
                n_y1 = 4'd0; n_y10 = y10 + 4'd1;
            end else n_y1 = y1 + 4'd1;
        end
        if (wr_en) begin
            case (wr_addr)
                SEL_D1:   n_d1   = wr_data;
                SEL_D10:  n_d10  = wr_data;
                SEL_MO1:  n_mo1  = wr_data;
                SEL_MO10: n_mo10 = wr_data;
                SEL_Y1:   n_y1   = wr_data;
                SEL_Y10:  n_y10  = wr_data;
                SEL_WK:   n_wk   = wr_data;
                default: ;
            endcase
        end
    end

    // Date digit registers; reset to day 01, month 01, year 00, weekday 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d1 <= 4'd1; d10 <= '0; mo1 <= 4'd1; mo10 <= '0; y1 <= '0; y10 <= '0; wk <= '0;
        end else begin
            d1 <= n_d1; d10 <= n_d10; mo1 <= n_mo1; mo10 <= n_mo10;
            y1 <= n_y1; y10 <= n_y10; wk <= n_wk;
        end
    end
endmodule

// File: rtl/bcd_calendar_core.sv
// Top: BCD calendar timekeeping chain.
// Joins the prescaler, time chain and date chain, latches the hour mode
// while reset_req is high, registers the carry pulses and muxes digit reads.
module bcd_calendar_core
    import cal_pkg::*;
#(
    parameter int DIV_BITS = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_tick,
    input  logic       stop_req,
    input  logic       reset_req,
    input  logic       mode24_sel,
    input  logic       adj30_req,
    input  logic       wr_en,
    input  logic [3:0] wr_addr,
    input  logic [3:0] wr_data,
    input  logic [3:0] rd_addr,
    output logic [3:0] rd_data,
    output logic       sec_carry,
    output logic       min_carry,
    output logic       hour_carry,
    output logic       std_pulse
);
    logic       sec_tick, run, mode_q;
    logic       c_sec, c_min, c_hr;
    logic [3:0] s1, s10, m1, m10, h1, h10;
    logic [3:0] d1, d10, mo1, mo10, y1, y10, wk;

    assign run = !stop_req && !reset_req;

    cal_prescaler #(.DIV_BITS(DIV_BITS)) u_pre (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .run(run),
        .clear(reset_req), .sec_tick(sec_tick), .tap64(std_pulse)
    );

    cal_time_chain u_time (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .adj_req(adj30_req),
        .mode24(mode_q), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .s1(s1), .s10(s10), .m1(m1), .m10(m10), .h1(h1), .h10(h10),
        .c_sec(c_sec), .c_min(c_min), .c_hr(c_hr)
    );

    cal_date_chain u_date (
        .clk(clk), .rst_n(rst_n), .inc_day(c_hr), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .d1(d1), .d10(d10), .mo1(mo1), .mo10(mo10), .y1(y1), .y10(y10), .wk(wk)
    );

    // Hour mode latch: only follows the select while reset_req is high.
    always_ff @(posedge clk) begin
        if (!rst_n)         mode_q <= 1'b1;
        else if (reset_req) mode_q <= mode24_sel;
    end

    // Carry pulse registers, aligned with the digit update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_carry <= 1'b0; min_carry <= 1'b0; hour_carry <= 1'b0;
        end else begin
            sec_carry <= c_sec; min_carry <= c_min; hour_carry <= c_hr;
        end
    end

    // Digit read multiplexer.
    always_comb begin
        case (rd_addr)
            SEL_S1:   rd_data = s1;
            SEL_S10:  rd_data = s10;
            SEL_M1:   rd_data = m1;
            SEL_M10:  rd_data = m10;
            SEL_H1:   rd_data = h1;
            SEL_H10:  rd_data = h10;
            SEL_D1:   rd_data = d1;
            SEL_D10:  rd_data = d10;
            SEL_MO1:  rd_data = mo1;
            SEL_MO10: rd_data = mo10;
            SEL_Y1:   rd_data = y1;
            SEL_Y10:  rd_data = y10;
            SEL_WK:   rd_data = wk;
            default:  rd_data = 4'd0;
        endcase
    end
endmodule

// File: rtl/cal_checker.sv
// Checker: temporal properties of the calendar chain, bound to the top.
module cal_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       stop_req,
    input logic       reset_req,
    input logic       adj30_req,
    input logic       wr_en,
    input logic       sec_carry,
    input logic       min_carry,
    input logic       hour_carry,
    input logic       mode_q,
    input logic [3:0] s1,
    input logic [3:0] s10
);
    // R2
    sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_carry |-> ($past(wr_en) || (s1 == 4'd0 && s10 == 4'd0)));
    // R3
    min_needs_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        min_carry |-> sec_carry);
    // R3
    hour_needs_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hour_carry |-> min_carry);
    // R9
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && !adj30_req && !wr_en) |=> ($stable(s1) && $stable(s10)));
    // R10
    reset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_req && !adj30_req && !wr_en) |=> ($stable(s1) && $stable(s10)));
    // R5
    mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reset_req |=> $stable(mode_q));
endmodule

bind bcd_calendar_core cal_checker u_chk (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .reset_req(reset_req),
    .adj30_req(adj30_req), .wr_en(wr_en), .sec_carry(sec_carry),
    .min_carry(min_carry), .hour_carry(hour_carry), .mode_q(mode_q),
    .s1(s1), .s10(s10)
);

// File: tb/tb_bcd_calendar_core.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module tb_bcd_calendar_core;
    localparam int DIVB = 7;

    logic clk = 1'b0, rst_n = 1'b0, ref_tick = 1'b1;
    logic stop_req = 1'b1, reset_req = 1'b0, mode24_sel = 1'b1, adj30_req = 1'b0;
    logic wr_en = 1'b0;
    logic [3:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
    logic [3:0] rd_data;
    logic sec_carry, min_carry, hour_carry, std_pulse;
    int n_checks = 0, n_fail = 0;
    bit finished = 1'b0;

    bcd_calendar_core #(.DIV_BITS(DIVB)) dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .stop_req(stop_req),
        .reset_req(reset_req), .mode24_sel(mode24_sel), .adj30_req(adj30_req),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .sec_carry(sec_carry), .min_carry(min_carry),
        .hour_carry(hour_carry), .std_pulse(std_pulse)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [3:0] d);
        rd_addr = a; #0.5; d = rd_data;
    endtask

    task automatic chk_dig(input string tag, input logic [3:0] a, input int exp);
        logic [3:0] d;
        rd(a, d);
        check($sformatf("%s sel%0d", tag, a), d, exp);
    endtask

    task automatic wr(input logic [3:0] a, input logic [3:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic set_time(input int h10, h1, m10, m1, s10, s1);
        wr(5, 4'(h10)); wr(4, 4'(h1)); wr(3, 4'(m10)); wr(2, 4'(m1)); wr(1, 4'(s10)); wr(0, 4'(s1));
    endtask

    task automatic set_date(input int d10, d1, mo10, mo1, y10, y1, w);
        wr(7, 4'(d10)); wr(6, 4'(d1)); wr(9, 4'(mo10)); wr(8, 4'(mo1));
        wr(11, 4'(y10)); wr(10, 4'(y1)); wr(12, 4'(w));
    endtask

    // Release stop until the seconds-ones digit changes, capture carries, stop again.
    task automatic step_sec(input string tag, output logic sc, mc, hc);
        logic [3:0] prev, cur;
        bit got;
        @(negedge clk); rd(0, prev); stop_req = 1'b0; got = 1'b0;
        for (int i = 0; i < 300 && !got; i++) begin
            @(negedge clk); rd(0, cur);
            if (cur != prev) got = 1'b1;
        end
        sc = sec_carry; mc = min_carry; hc = hour_carry;
        stop_req = 1'b1;
        check({tag, " second step seen"}, got, 1);
    endtask

    task automatic set_mode(input logic m);
        @(negedge clk); reset_req = 1'b1; mode24_sel = m;
        @(negedge clk); @(negedge clk); reset_req = 1'b0;
    endtask

    task automatic t_reset_state();
        chk_dig("R1", 0, 0); chk_dig("R1", 1, 0); chk_dig("R1", 2, 0); chk_dig("R1", 3, 0);
        chk_dig("R1", 4, 0); chk_dig("R1", 5, 0); chk_dig("R1", 6, 1); chk_dig("R1", 7, 0);
        chk_dig("R1", 8, 1); chk_dig("R1", 9, 0); chk_dig("R1", 10, 0); chk_dig("R1", 11, 0);
        chk_dig("R1", 12, 0); chk_dig("R1", 13, 0);
        check("R1 carries", {sec_carry, min_carry, hour_carry}, 0);
    endtask

    task automatic t_seconds();
        logic sc, mc, hc;
        set_time(0, 8, 1, 4, 5, 8);
        step_sec("R2", sc, mc, hc);
        chk_dig("R2 59", 0, 9); chk_dig("R2 59", 1, 5); check("R2 no carry", sc, 0);
        step_sec("R2", sc, mc, hc);
        chk_dig("R2 wrap", 0, 0); chk_dig("R2 wrap", 1, 0); chk_dig("R2 min", 2, 5);
        check("R2 sec_carry pulse", sc, 1); check("R2 min_carry", mc, 0);
        @(negedge clk); check("R2 pulse one cycle", sec_carry, 0);
    endtask

    task automatic t_day_24();
        logic sc, mc, hc;
        set_date(1, 5, 0, 3, 2, 1, 6);
        set_time(2, 3, 5, 9, 5, 9);
        step_sec("R3", sc, mc, hc);
        chk_dig("R3 h1", 4, 0); chk_dig("R3 h10", 5, 0); chk_dig("R3 m10", 3, 0);
        chk_dig("R3 day", 6, 6); check("R3 hour_carry", hc, 1); check("R3 min_carry", mc, 1);
        chk_dig("R12 weekday wrap", 12, 0);
        set_time(1, 9, 5, 9, 5, 9);
        step_sec("R3", sc, mc, hc);
        chk_dig("R3 19->20 h1", 4, 0); chk_dig("R3 19->20 h10", 5, 2); check("R3 no hour carry", hc, 0);
        chk_dig("R12 weekday hold", 12, 0);
    endtask

    task automatic t_twelve_hour();
        logic sc, mc, hc;
        set_mode(1'b0);
        set_date(1, 0, 0, 6, 2, 2, 2);
        set_time(1, 1, 5, 9, 5, 9);
        step_sec("R4", sc, mc, hc);
        chk_dig("R4 11am->12pm h1", 4, 2); chk_dig("R4 pm flag", 5, 5); check("R4 no day", hc, 0);
        chk_dig("R4 day held", 6, 0);
        set_time(5, 2, 5, 9, 5, 9);
        step_sec("R4", sc, mc, hc);
        chk_dig("R4 12->1 h1", 4, 1); chk_dig("R4 12->1 h10", 5, 4);
        set_time(4, 9, 5, 9, 5, 9);
        step_sec("R4", sc, mc, hc);
        chk_dig("R4 9->10 h1", 4, 0); chk_dig("R4 9->10 h10", 5, 5);
        set_time(5, 1, 5, 9, 5, 9);
        step_sec("R4", sc, mc, hc);
        chk_dig("R4 11pm->12am h1", 4, 2); chk_dig("R4 am flag", 5, 1);
        check("R4 day carry", hc, 1); chk_dig("R4 day", 6, 1); chk_dig("R12 weekday", 12, 3);
    endtask

    task automatic t_mode_lock();
        logic sc, mc, hc;
        @(negedge clk); mode24_sel = 1'b1;
        repeat (4) @(negedge clk);
        set_time(1, 2, 5, 9, 5, 9);
        step_sec("R5", sc, mc, hc);
        chk_dig("R5 still 12h h1", 4, 1); chk_dig("R5 still 12h h10", 5, 0);
        set_mode(1'b1);
    endtask

    task automatic t_leap();
        logic sc, mc, hc;
        set_date(2, 8, 0, 2, 0, 4, 0);
        set_time(2, 3, 5, 9, 5, 9);
        step_sec("R6", sc, mc, hc);
        chk_dig("R6 leap 29 d10", 7, 2); chk_dig("R6 leap 29 d1", 6, 9); chk_dig("R6 feb", 8, 2);
        set_time(2, 3, 5, 9, 5, 9);
        step_sec("R6", sc, mc, hc);
        chk_dig("R6 mar1 d1", 6, 1); chk_dig("R6 mar1 d10", 7, 0); chk_dig("R6 mar", 8, 3);
        set_date(2, 8, 0, 2, 0, 3, 0);
        set_time(2, 3, 5, 9, 5, 9);
        step_sec("R6", sc, mc, hc);
        chk_dig("R6 common year d1", 6, 1); chk_dig("R6 common year mon", 8, 3);
        set_date(2, 8, 0, 2, 0, 0, 0);
        set_time(2, 3, 5, 9, 5, 9);
        step_sec("R6", sc, mc, hc);
        chk_dig("R6 year00 d1", 6, 9); chk_dig("R6 year00 mon", 8, 2);
    endtask

    task automatic t_months();
        logic sc, mc, hc;
        set_date(3, 0, 0, 4, 5, 5, 1);
        set_time(2, 3, 5, 9, 5, 9);
        step_sec("R7", sc, mc, hc);
        chk_dig("R7 apr30 d1", 6, 1); chk_dig("R7 may", 8, 5);
        set_date(3, 0, 0, 7, 5, 5, 1);
        set_time(2, 3, 5, 9, 5, 9);
        step_sec("R7", sc, mc, hc);
        chk_dig("R7 jul30->31 d1", 6, 1); chk_dig("R7 jul30->31 d10", 7, 3); chk_dig("R7 jul", 8, 7);
        set_date(3, 1, 1, 2, 9, 9, 4);
        set_time(2, 3, 5, 9, 5, 9);
        step_sec("R7", sc, mc, hc);
        chk_dig("R7 jan d1", 6, 1); chk_dig("R7 jan mo1", 8, 1); chk_dig("R7 jan mo10", 9, 0);
        chk_dig("R7 year y1", 10, 0); chk_dig("R7 year y10", 11, 0);
    endtask

    task automatic t_adjust();
        set_time(0, 5, 1, 7, 2, 9);
        @(negedge clk); adj30_req = 1'b1; @(negedge clk); adj30_req = 1'b0;
        chk_dig("R8 down s1", 0, 0); chk_dig("R8 down s10", 1, 0); chk_dig("R8 down min", 2, 7);
        check("R8 down no carry", sec_carry, 0);
        set_time(0, 5, 5, 9, 4, 5);
        @(negedge clk); adj30_req = 1'b1; @(negedge clk); adj30_req = 1'b0;
        chk_dig("R8 up s10", 1, 0); chk_dig("R8 up m10", 3, 0); chk_dig("R8 up hour", 4, 6);
        check("R8 up sec_carry", sec_carry, 1); check("R8 up min_carry", min_carry, 1);
    endtask

    task automatic t_stop();
        logic std0, std1;
        set_time(0, 1, 0, 2, 0, 3);
        stop_req = 1'b1;
        repeat (300) @(negedge clk);
        chk_dig("R9 frozen s1", 0, 3); chk_dig("R9 frozen s10", 1, 0);
        std0 = std_pulse; @(negedge clk); std1 = std_pulse;
        check("R13 held when stopped", std1, std0);
        stop_req = 1'b0;
        @(negedge clk); std0 = std_pulse; @(negedge clk); std1 = std_pulse;
        check("R13 toggles each ref tick", std1, !std0);
        stop_req = 1'b1;
    endtask

    task automatic t_reset_ctrl();
        set_time(0, 1, 0, 2, 0, 3);
        @(negedge clk); reset_req = 1'b1; stop_req = 1'b0;
        repeat (300) @(negedge clk);
        chk_dig("R10 held", 0, 3);
        reset_req = 1'b0;
        repeat (127) @(negedge clk);
        chk_dig("R10 before strobe", 0, 3);
        @(negedge clk);
        chk_dig("R10 strobe at 2^DIV", 0, 4);
        @(negedge clk); reset_req = 1'b1;
        repeat (2) @(negedge clk); reset_req = 1'b0;
        repeat (127) @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'd0; wr_data = 4'd7;
        @(negedge clk); wr_en = 1'b0; stop_req = 1'b1;
        chk_dig("R11 write wins", 0, 7); chk_dig("R11 tens untouched", 1, 0);
    endtask

    initial begin
        #(5.0 * 190000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_seconds();
        t_day_24();
        t_twelve_hour();
        t_mode_lock();
        t_leap();
        t_months();
        t_adjust();
        t_stop();
        t_reset_ctrl();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule